// File: doc/BRIEF.md
# Consecutive-Ones Run Detector, Dual Output Style

The block watches a one-bit serial stream that is sampled on every rising clock edge. It flags when two or more ones have arrived back to back. Two detectors share the same input and run in parallel, so their timing can be compared directly.

The first detector has a registered flag. Its three-state machine sits on two flip-flops and the flag is a pure function of the stored state. The second detector has an input-dependent flag. A single flip-flop remembers whether the last sampled bit was a one, and the flag is that bit ANDed with the live input.

The input-dependent flag therefore reports the run one cycle earlier. It is only meaningful just before a clock edge, because it follows any movement of the input in between. A synchronous, active-high reset returns both detectors to idle.

Top module: `dual_run_detector`

## Requirements
- R1: While `rst` is high at a rising edge, both detectors go to idle at that edge. After it, `flag_reg` is 0, and `flag_live` is 0 whatever the value of `bit_in`.
- R2: After a rising edge, `flag_reg` is 1 exactly when the last two bits sampled since reset were both 1. Any sampled 0 clears it at that edge. Each further sampled 1 keeps it high.
- R3: `flag_reg` depends only on stored state. Changing `bit_in` between two rising edges never changes `flag_reg` within that cycle.
- R4: `flag_live` equals `bit_in` AND (the last bit sampled since reset was 1). It follows `bit_in` combinationally within the cycle.
- R5: If `flag_live` is 1 just before a rising edge with `rst` low, `flag_reg` is 1 after that edge. The live flag leads the registered one by exactly one cycle.
- R6: Reset takes priority over the input. A 1 on `bit_in` during a reset edge does not count toward a run, so the first cycle after reset shows `flag_live` = 0 even with `bit_in` = 1.
- R7: The registered state is stored with idle = 00, one seen = 01 and run = 10 (high bit, low bit). The registered flag is the high state bit. The unused code 11 steps to 10 on a sampled 1 and to 00 on a sampled 0, and its flag reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial input bit, sampled each rising edge |
| flag_reg | output | 1 | Run flag from the state-only detector |
| flag_live | output | 1 | Run flag from the input-dependent detector |

## Verification
The input-dependent flag is due in the same cycle as the second consecutive one. The bench compares it with a reference built from the previous sampled bit, at a point just before the rising edge, where that flag is defined to be valid. The registered flag is due one edge later. It is compared, in the following cycle, with the value the reference gave the live flag in the cycle before. Mid-cycle input toggles are checked separately, to show that the registered flag holds while the live flag follows the input.

// File: rtl/run_det_pkg.sv
package run_det_pkg;

    // Encoding of the registered detector (hi, lo)
    localparam logic [1:0] RUN_IDLE = 2'b00;
    localparam logic [1:0] RUN_ONE  = 2'b01;
    localparam logic [1:0] RUN_MANY = 2'b10;

    typedef struct packed {
        logic hi;
        logic lo;
    } reg_state_t;

    typedef struct packed {
        logic seen;
    } live_state_t;

endpackage

// File: rtl/run_reg_fsm.sv
module run_reg_fsm
    import run_det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic flag
);

    reg_state_t st_q;
    reg_state_t st_d;

    // Hand-derived equations; code 11 falls to 10 or 00 like the run state (R7)
    always_comb begin
        st_d.hi = bit_in & (st_q.hi | st_q.lo);
        st_d.lo = bit_in & ~st_q.hi & ~st_q.lo;
        if (rst) begin
            st_d = RUN_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Flag is the high state bit only
    assign flag = st_q.hi;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (st_q == RUN_IDLE));

    p_zero_clears_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_in |=> !flag);

    p_second_one_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_in && (st_q == RUN_ONE || st_q == RUN_MANY)) |=> flag);

    p_first_one_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_in && st_q == RUN_IDLE) |=> (st_q == RUN_ONE));

endmodule

// File: rtl/run_live_fsm.sv
module run_live_fsm
    import run_det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic flag
);

    live_state_t st_q;
    live_state_t st_d;

    always_comb begin
        st_d.seen = bit_in;
        if (rst) begin
            st_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag = bit_in & st_q.seen;

    p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> !st_q.seen);

    p_tracks_input_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (st_q.seen == $past(bit_in)));

endmodule

// File: rtl/dual_run_detector.sv
module dual_run_detector (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic flag_reg,
    output logic flag_live
);

    run_reg_fsm u_reg (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .flag   (flag_reg)
    );

    run_live_fsm u_live (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bit_in),
        .flag   (flag_live)
    );

    p_live_leads_r5: assert property (@(posedge clk) disable iff (rst)
        flag_live |=> flag_reg);

    p_reg_lags_r5: assert property (@(posedge clk) disable iff (rst)
        !flag_live |=> !flag_reg);

endmodule

// File: tb/dual_run_detector_test.sv
`timescale 1ns/1ps
module dual_run_detector_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic flag_reg;
    logic flag_live;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model: last sampled bit and expected registered flag
    bit ref_prev = 1'b0;
    bit ref_reg = 1'b0;

    always #2.5 clk = ~clk;

    dual_run_detector uut (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .flag_reg  (flag_reg),
        .flag_live (flag_live)
    );

    function automatic bit exp_live(bit b, bit prev);
        return b & prev;
    endfunction

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // one cycle: drive after negedge, optional mid-cycle toggle, check before posedge
    task automatic step(bit b, bit wiggle);
        @(negedge clk);
        #0.2 bit_in = b;
        #0.6;
        check("R2", flag_reg, ref_reg);
        if (wiggle) begin
            bit_in = ~b;
            #0.4;
            check("R3", flag_reg, ref_reg);
            check("R4", flag_live, exp_live(~b, ref_prev));
            bit_in = b;
        end
        #0.5;
        check("R4", flag_live, exp_live(b, ref_prev));
        check("R3", flag_reg, ref_reg);
        @(posedge clk);
        ref_reg = exp_live(b, ref_prev);
        ref_prev = b;
    endtask

    task automatic do_reset(bit b);
        @(negedge clk);
        #0.2 rst = 1'b1;
        bit_in = b;
        @(posedge clk);
        #0.4 rst = 1'b0;
        ref_prev = 1'b0;
        ref_reg = 1'b0;
        check("R1", flag_reg, 1'b0);
        check("R6", flag_live, 1'b0);
    endtask

    initial begin
        #(5.0 * 60000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240327));
        // reset state, with input high to show reset priority (R1, R6)
        do_reset(1'b1);
        step(1'b1, 1'b0);   // first one after reset: live flag 0 (R6)
        step(1'b1, 1'b0);   // second one: live flag high (R4)
        step(1'b1, 1'b1);   // registered flag high, toggles mid-cycle (R3)
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);   // zero cleared registered flag (R2)
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        // reset in the middle of a run clears everything (R1)
        do_reset(1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // constrained random: biased toward ones, occasional reset
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 2) begin
                do_reset(($urandom % 2) == 0);
            end else begin
                step((($urandom % 100) < 65), (($urandom % 4) == 0));
            end
        end
        // final boundary: long run of ones then a single zero (R5)
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b0);
        end
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule